// File: doc/BRIEF.md
# Interval Timer with Pulse Counting

This block is a 16-bit down-counter that a host reaches through an 8-bit register port at two addresses. One mode input picks the count source. In interval mode the counter steps down once per system clock. In event mode it steps down once for each high-to-low transition seen on an external, asynchronous input pin. When the count passes below zero an interrupt flag is raised. The flag can be raised only once per load of the counter. It comes back only after the host writes the high byte again.

The low-byte address holds a write-only latch for the low half of the next count, and reads back the live low counter byte. The high-byte address writes the upper half of the counter directly. That write also copies the latch into the lower half and starts the timing run. Reading the live low byte is one way to acknowledge the flag. The interrupt request output is the flag gated by an enable input.

Top module: `pulse_interval_timer`

## Requirements
- R1: Reset (rst_n low at a clock edge) sets the counter and the low latch to zero, clears the flag and leaves flag setting disarmed. Until the first high-byte write the flag stays clear, even while the counter wraps through zero.
- R2: A write with bus_addr=0 stores bus_wdata in the low latch only. The counter and the flag do not change, and the stored value shows up only at the next high-byte write.
- R3: A write with bus_addr=1 loads the counter with {bus_wdata, low latch} at that clock edge, clears the flag and arms flag setting. This takes precedence over a decrement in the same cycle.
- R4: bus_rdata returns counter bits [7:0] when bus_addr=0 and bits [15:8] when bus_addr=1, in the same cycle. A read (bus_cs=1, bus_we=0) with bus_addr=0 clears the flag at the next edge. A read with bus_addr=1 leaves the flag unchanged.
- R5: With cnt_mode=0 (interval) the counter decreases by one at every clock edge that is not a high-byte write. It wraps from 0x0000 to 0xFFFF.
- R6: The flag is set at the edge where the armed counter steps from 0x0000 to 0xFFFF. After a load value V in interval mode, the flag reads 1 exactly V+1 edges after the load edge.
- R7: After the flag has been set once, flag setting is disarmed. Later passes through zero do not set the flag again until the next high-byte write.
- R8: With cnt_mode=1 (events) the counter decreases by one for each falling edge of evt_pin after a two-stage synchronizer, at most once per clock. Rising edges and a steady pin leave the counter unchanged.
- R9: In event mode the flag sets when the count passes below zero, counting continues, and the R7 disarm applies.
- R10: irq equals irq_flag AND irq_en.
- R11: When a timeout and a low-byte read fall in the same cycle, the flag ends set. When a timeout and a high-byte write fall in the same cycle, the write wins: the flag ends clear, the new value is loaded and flag setting is re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = low byte, 1 = high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Counter byte selected by bus_addr |
| cnt_mode | input | 1 | 0 = interval timing, 1 = event counting |
| irq_en | input | 1 | Interrupt request enable |
| evt_pin | input | 1 | Asynchronous event input, counted on falling edges |
| irq_flag | output | 1 | Timeout flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The timeout that sets the flag can fall in the same clock as either of the two host actions that clear it. The bench provokes both cases in interval mode. It loads a small value, counts clock edges until the counter reads zero, and then issues a low-byte read or a high-byte write on the very edge where the wrap happens. The first case passes if the flag stays set and the read data was 0x00. The second passes if the flag is clear, the new value is loaded, and a later timeout sets the flag again, which shows the write re-armed it.

// File: rtl/pit_pkg.sv
// Shared types for the pulse/interval timer.
// Assumes: one host access per cycle; byte lane is fixed by the count width.
package pit_pkg;

    // Count source selection.
    typedef enum logic {
        MODE_INTERVAL = 1'b0,
        MODE_EVENTS   = 1'b1
    } cnt_mode_e;

    // Which byte of the counter a host access addresses.
    typedef enum logic {
        SEL_LOW  = 1'b0,
        SEL_HIGH = 1'b1
    } byte_sel_e;

    // One-cycle decoded host operations.
    typedef struct packed {
        logic wr_low;
        logic wr_high;
        logic rd_low;
    } host_op_t;

endpackage

// File: rtl/pit_edge_sync.sv
// Synchronizes an asynchronous pin and flags a high-to-low transition.
// Assumes: STAGES >= 1; the pin idles high, so all stages reset to 1 and
// no edge is reported right after reset. One pulse per detected edge.
module pit_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);

    // chain_q[STAGES-1] is the synchronized pin; chain_q[STAGES] its history.
    logic [STAGES:0] chain_q;

    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First capture flop, sees the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[i] <= 1'b1;
                else        chain_q[i] <= pin_i;
            end
        end else begin : g_next
            // Later stages shift the sampled value along.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[i] <= 1'b1;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    // Falling edge: previous synchronized value high, current low.
    always_comb fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/pit_host_port.sv
// Host register port: decodes one-cycle accesses, keeps the low-byte latch,
// and returns the addressed live counter byte.
// Assumes: bus_cs is a single-cycle strobe; read data is combinational.
module pit_host_port
    import pit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_i,
    input  logic                  we_i,
    input  logic                  addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [2*DATA_W-1:0]   cnt_i,
    output host_op_t              op_o,
    output logic [DATA_W-1:0]     latch_o,
    output logic [DATA_W-1:0]     rdata_o
);

    localparam int CNT_W = 2 * DATA_W;

    byte_sel_e sel;
    logic [DATA_W-1:0] latch_q;

    // Decode the access into per-operation strobes.
    always_comb begin
        sel          = byte_sel_e'(addr_i);
        op_o.wr_low  = cs_i &  we_i & (sel == SEL_LOW);
        op_o.wr_high = cs_i &  we_i & (sel == SEL_HIGH);
        op_o.rd_low  = cs_i & ~we_i & (sel == SEL_LOW);
    end

    // Low-byte latch, written only through the low address.
    always_ff @(posedge clk) begin
        if (!rst_n)           latch_q <= '0;
        else if (op_o.wr_low) latch_q <= wdata_i;
    end

    // Read mux over the live counter halves.
    always_comb begin
        if (sel == SEL_HIGH) rdata_o = cnt_i[CNT_W-1:DATA_W];
        else                 rdata_o = cnt_i[DATA_W-1:0];
    end

    always_comb latch_o = latch_q;

endmodule

// File: rtl/pit_down_counter.sv
// Down-counter with single-shot timeout flag.
// Assumes: host strobes come from pit_host_port; a high-byte write has
// priority over stepping; a timeout set wins over a low-byte read clear.
module pit_down_counter
    import pit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  host_op_t              op_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [DATA_W-1:0]     latch_i,
    input  cnt_mode_e             mode_i,
    input  logic                  fall_i,
    output logic [2*DATA_W-1:0]   cnt_o,
    output logic                  flag_o
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             flag_q;
    logic             step;
    logic             wrap;
    logic             fire;

    // Count source: every clock, or one synchronized falling edge.
    always_comb begin
        step = (mode_i == MODE_INTERVAL) ? 1'b1 : fall_i;
        wrap = step && (cnt_q == '0);
        fire = wrap && armed_q && !op_i.wr_high;
    end

    // Counter: load on high write, otherwise step down.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (op_i.wr_high) cnt_q <= {wdata_i, latch_i};
        else if (step)         cnt_q <= cnt_q - 1'b1;
    end

    // Arm bit: a load arms, the first timeout disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)            armed_q <= 1'b0;
        else if (op_i.wr_high) armed_q <= 1'b1;
        else if (fire)         armed_q <= 1'b0;
    end

    // Flag: cleared by load, set by timeout, cleared by low read.
    always_ff @(posedge clk) begin
        if (!rst_n)            flag_q <= 1'b0;
        else if (op_i.wr_high) flag_q <= 1'b0;
        else if (fire)         flag_q <= 1'b1;
        else if (op_i.rd_low)  flag_q <= 1'b0;
    end

    always_comb begin
        cnt_o  = cnt_q;
        flag_o = flag_q;
    end

endmodule

// File: rtl/pulse_interval_timer.sv
// Top level: host port, pin synchronizer and down-counter.
// Assumes: evt_pin is asynchronous; all other inputs are synchronous to clk.
module pulse_interval_timer
    import pit_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cnt_mode,
    input  logic              irq_en,
    input  logic              evt_pin,
    output logic              irq_flag,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    host_op_t          host_op;
    logic [DATA_W-1:0] latch_val;
    logic [CNT_W-1:0]  cnt_val;
    logic              evt_fall;
    logic              flag_val;
    cnt_mode_e         mode_sel;

    // Mode input mapped to the shared type.
    always_comb mode_sel = cnt_mode_e'(cnt_mode);

    pit_host_port #(.DATA_W(DATA_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (bus_cs),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .cnt_i   (cnt_val),
        .op_o    (host_op),
        .latch_o (latch_val),
        .rdata_o (bus_rdata)
    );

    pit_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (evt_pin),
        .fall_o (evt_fall)
    );

    pit_down_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (host_op),
        .wdata_i (bus_wdata),
        .latch_i (latch_val),
        .mode_i  (mode_sel),
        .fall_i  (evt_fall),
        .cnt_o   (cnt_val),
        .flag_o  (flag_val)
    );

    // Interrupt request gating.
    always_comb begin
        irq_flag = flag_val;
        irq      = flag_val & irq_en;
    end

endmodule

// File: rtl/pit_checker.sv
// Property checker for pulse_interval_timer, attached with bind below.
// Assumes: signals are sampled at the rising clock edge.
module pit_checker #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_high,
    input logic                rd_low,
    input logic                mode,
    input logic                fall,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W-1:0]   latch,
    input logic [2*DATA_W-1:0] cnt,
    input logic                flag,
    input logic                irq_en,
    input logic                irq
);

    // R10: no request while disabled.
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R3: high write loads {data, latch} and clears the flag.
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_high |=> (!flag && cnt == {$past(wdata), $past(latch)}));

    // R4: low read clears the flag when no timeout can coincide.
    p_rdlow_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_low && !wr_high && cnt != '0) |=> !flag);

    // R5: interval mode steps down by one each clock.
    p_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !wr_high) |=> ((cnt + 1'b1) == $past(cnt)));

    // R8: event mode holds without a detected falling edge.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !wr_high && !fall) |=> $stable(cnt));

    // R6: the flag only rises out of a zero count.
    p_flag_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(cnt) == '0));

endmodule

bind pulse_interval_timer pit_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_high (host_op.wr_high),
    .rd_low  (host_op.rd_low),
    .mode    (cnt_mode),
    .fall    (evt_fall),
    .wdata   (bus_wdata),
    .latch   (latch_val),
    .cnt     (cnt_val),
    .flag    (flag_val),
    .irq_en  (irq_en),
    .irq     (irq)
);

// File: tb/pulse_interval_timer_tb.sv
module pulse_interval_timer_tb;

    typedef struct packed {
        logic [7:0]  lat;
        logic [7:0]  hi;
        logic [15:0] wait_n;
        logic [15:0] exp_cnt;
        logic        exp_flag;
    } vec_t;

    // Interval-mode load/wait vectors (R5, R6).
    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{8'h05, 8'h00, 16'd3,  16'h0002, 1'b0},
        '{8'h05, 8'h00, 16'd5,  16'h0000, 1'b0},
        '{8'h05, 8'h00, 16'd6,  16'hFFFF, 1'b1},
        '{8'h05, 8'h00, 16'd9,  16'hFFFC, 1'b1},
        '{8'h00, 8'h01, 16'd10, 16'h00F6, 1'b0},
        '{8'h00, 8'h00, 16'd1,  16'hFFFF, 1'b1},
        '{8'h00, 8'h00, 16'd0,  16'h0000, 1'b0},
        '{8'h34, 8'h12, 16'd16, 16'h1224, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cnt_mode = 1'b0;
    logic       irq_en = 1'b0;
    logic       evt_pin = 1'b1;
    logic       irq_flag;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pulse_interval_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_mode(cnt_mode), .irq_en(irq_en), .evt_pin(evt_pin),
        .irq_flag(irq_flag), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic a, input logic [7:0] d);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_cs = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic peek(output logic [15:0] v);
        bus_addr = 1'b0; #1 v[7:0] = bus_rdata;
        bus_addr = 1'b1; #1 v[15:8] = bus_rdata;
        bus_addr = 1'b0;
    endtask

    task automatic load(input logic [7:0] lat, input logic [7:0] hi);
        wr(1'b0, lat);
        wr(1'b1, hi);
    endtask

    task automatic pulse();
        evt_pin = 1'b0;
        repeat (4) @(negedge clk);
        evt_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        irq_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        peek(v);
        check("R1", "count in reset", {16'h0, v}, 32'h0);
        rst_n = 1'b1;
        peek(v);
        check("R1", "count after reset", {16'h0, v}, 32'h0);
        check("R1", "flag after reset", {31'h0, irq_flag}, 32'h0);
        check("R10", "irq after reset", {31'h0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        peek(v);
        check("R5", "free decrement wraps", {16'h0, v}, 32'hFFFD);
        check("R1", "no flag before first load", {31'h0, irq_flag}, 32'h0);

        // Vector walk, interval mode.
        for (int i = 0; i < NVEC; i++) begin
            load(VEC[i].lat, VEC[i].hi);
            repeat (int'(VEC[i].wait_n)) @(negedge clk);
            peek(v);
            check("R5", $sformatf("vec %0d count", i), {16'h0, v}, {16'h0, VEC[i].exp_cnt});
            check("R6", $sformatf("vec %0d flag", i), {31'h0, irq_flag}, {31'h0, VEC[i].exp_flag});
        end

        // R10, R4, R7: flag handling in interval mode.
        load(8'h02, 8'h00);
        repeat (3) @(negedge clk);
        check("R6", "flag at V+1", {31'h0, irq_flag}, 32'h1);
        check("R10", "irq enabled", {31'h0, irq}, 32'h1);
        irq_en = 1'b0;
        #1 check("R10", "irq disabled", {31'h0, irq}, 32'h0);
        irq_en = 1'b1;
        rd(1'b1, b);
        check("R4", "high byte read data", {24'h0, b}, 32'hFF);
        check("R4", "high read keeps flag", {31'h0, irq_flag}, 32'h1);
        rd(1'b0, b);
        check("R4", "low byte read data", {24'h0, b}, 32'hFE);
        check("R4", "low read clears flag", {31'h0, irq_flag}, 32'h0);
        repeat (65540) @(negedge clk);
        check("R7", "no second flag after wrap", {31'h0, irq_flag}, 32'h0);

        // Event mode: R8, R2, R3, R9.
        cnt_mode = 1'b1;
        load(8'h03, 8'h00);
        repeat (5) @(negedge clk);
        peek(v);
        check("R8", "steady pin holds count", {16'h0, v}, 32'h0003);
        wr(1'b0, 8'hAA);
        peek(v);
        check("R2", "latch write leaves count", {16'h0, v}, 32'h0003);
        check("R2", "latch write leaves flag", {31'h0, irq_flag}, 32'h0);
        wr(1'b1, 8'h00);
        peek(v);
        check("R3", "latch used at high write", {16'h0, v}, 32'h00AA);
        load(8'h03, 8'h00);
        pulse(); pulse();
        peek(v);
        check("R8", "two pulses counted", {16'h0, v}, 32'h0001);
        check("R9", "no flag before passing zero", {31'h0, irq_flag}, 32'h0);
        pulse(); pulse();
        peek(v);
        check("R9", "count past zero", {16'h0, v}, 32'hFFFF);
        check("R9", "flag on passing zero", {31'h0, irq_flag}, 32'h1);
        rd(1'b0, b);
        pulse();
        peek(v);
        check("R9", "counting continues", {16'h0, v}, 32'hFFFE);
        check("R9", "flag stays clear", {31'h0, irq_flag}, 32'h0);

        // R11: coincidences in interval mode.
        cnt_mode = 1'b0;
        load(8'h03, 8'h00);
        repeat (3) @(negedge clk);
        rd(1'b0, b);
        check("R11", "read data at timeout", {24'h0, b}, 32'h00);
        check("R11", "set wins over low read", {31'h0, irq_flag}, 32'h1);
        load(8'h03, 8'h00);
        repeat (3) @(negedge clk);
        wr(1'b1, 8'h00);
        peek(v);
        check("R11", "write wins: count", {16'h0, v}, 32'h0003);
        check("R11", "write wins: flag", {31'h0, irq_flag}, 32'h0);
        repeat (4) @(negedge clk);
        check("R11", "re-armed by write", {31'h0, irq_flag}, 32'h1);

        done = 1;
        summary();
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule